// File: doc/BRIEF.md
# DRAM Open-Page Tracker

This block records which DRAM pages are open across a memory array made of several rows, each split into internal banks. Each access arrives already decoded into a row index, a bank index and a row address. The block compares it with its stored state and reports one of four outcomes. A hit means the page is already open. A miss means the bank, or a conflicting page elsewhere, must be precharged before the activate. An empty result means only an activate is needed. An error means the bank index is out of range for that row. The open state is then updated to match what the command sequencer will do.

The number of pages a row may keep open is set row by row by two configuration bits: a slow-page row type, and a device-density flag for synchronous rows. A slow-page row allows a single page, and while that page is open it is the only open page in the whole array. A low-density synchronous row allows two banks and a high-density one allows four. A close-all input, used before refresh, clears every open flag. Configuration must be stable outside reset.

Top module: `dram_page_tracker`

## Requirements
- R1: An access whose target bank is open with an equal stored row address reports HIT (code 0) and leaves the open flags unchanged.
- R2: An access whose target bank is open with a different stored row address reports MISS (code 1), and the new row address replaces the stored one.
- R3: An access to a closed bank, with no conflicting open page, reports EMPTY (code 2) and sets that bank's open flag.
- R4: On a row with cfg_edo set only bank 0 is legal. Opening its page closes every other open page in the array and reports MISS if any page was closed. While such a page is open it is the only open page.
- R5: On a synchronous row with cfg_big clear, banks 0 and 1 can be open at the same time.
- R6: On a synchronous row with cfg_big set, banks 0 to 3 can be open at the same time.
- R7: An access to a synchronous row while a page on a cfg_edo row is open closes that page and reports MISS.
- R8: A bank index at or above the row's limit (1, 2 or 4) reports ERROR (code 3) and changes no state.
- R9: close_all clears all open flags at the next clock edge. An access presented in the same cycle is dropped and produces no result.
- R10: After reset no page is open. result_valid rises exactly one cycle after each accepted access and is low otherwise.
- R11: open_flags bit row*4+bank shows whether that bank of that row holds an open page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_edo | input | 2**ROW_W | Per row: row uses slow-page single-bank memory |
| cfg_big | input | 2**ROW_W | Per row: synchronous devices have four banks instead of two |
| acc_valid | input | 1 | Access strobe |
| acc_row | input | ROW_W | Decoded row index |
| acc_bank | input | 2 | Decoded internal bank index |
| acc_raddr | input | RA_W | Row address within the bank |
| close_all | input | 1 | Close every open page (refresh) |
| result_valid | output | 1 | Classification valid |
| result_kind | output | 2 | 0 hit, 1 miss, 2 empty, 3 error |
| open_flags | output | 2**ROW_W*4 | Open flag per row and bank |

## Verification
The bench builds the tracker with ROW_W=2 (four rows, sixteen flag slots) and RA_W=4. With that size it can sweep every row and bank slot over repeated and changed row addresses, under three row-type mixes: mixed, all synchronous, and all slow-page. Every transition between hit, miss, empty and error is reached, including the cross-row closures a slow-page row forces. The whole flag vector is compared with a bench model after every access.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int BANKS_PER_ROW = 4;
  localparam int BANK_W = 2;

  typedef enum logic [1:0] {
    KIND_HIT   = 2'd0,
    KIND_MISS  = 2'd1,
    KIND_EMPTY = 2'd2,
    KIND_ERROR = 2'd3
  } kind_e;

  // Number of banks a row may keep open, from its type bits.
  function automatic logic [BANK_W:0] bank_limit(input logic edo, input logic big);
    if (edo) return (BANK_W+1)'(1);
    else if (big) return (BANK_W+1)'(4);
    else return (BANK_W+1)'(2);
  endfunction

  // Flat slot index of a row/bank pair.
  function automatic int unsigned slot_of(input int unsigned row, input int unsigned bank);
    return row * BANKS_PER_ROW + bank;
  endfunction
endpackage

// File: rtl/dpt_rowcfg.sv
module dpt_rowcfg
  import dpt_pkg::*;
#(
  parameter int ROW_W = 3,
  localparam int NUM_ROWS = 1 << ROW_W,
  localparam int SLOTS = NUM_ROWS * BANKS_PER_ROW
) (
  input  logic [NUM_ROWS-1:0] cfg_edo,
  input  logic [NUM_ROWS-1:0] cfg_big,
  input  logic [ROW_W-1:0]    acc_row,
  input  logic [BANK_W-1:0]   acc_bank,
  output logic                sel_edo,
  output logic                bad_bank,
  output logic [SLOTS-1:0]    edo_slots,
  output logic [SLOTS-1:0]    legal_slots
);
  logic [BANK_W:0] sel_limit;

  assign sel_edo   = cfg_edo[acc_row];
  assign sel_limit = bank_limit(cfg_edo[acc_row], cfg_big[acc_row]);
  assign bad_bank  = {1'b0, acc_bank} >= sel_limit;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar b = 0; b < BANKS_PER_ROW; b++) begin : g_bank
      assign edo_slots[r*BANKS_PER_ROW+b]   = cfg_edo[r];
      assign legal_slots[r*BANKS_PER_ROW+b] =
        (BANK_W+1)'(b) < bank_limit(cfg_edo[r], cfg_big[r]);
    end
  end
endmodule

// File: rtl/dpt_lookup.sv
module dpt_lookup
  import dpt_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int RA_W = 14,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]      open_flags,
  input  logic [SLOTS*RA_W-1:0] addr_flat,
  input  logic [SLOT_W-1:0]     slot,
  input  logic [RA_W-1:0]       raddr,
  input  logic                  sel_edo,
  input  logic [SLOTS-1:0]      edo_slots,
  output kind_e                 kind,
  output logic [SLOTS-1:0]      kill_mask,
  output logic                  tgt_open,
  output logic                  conflict
);
  logic [SLOTS-1:0] self_mask;
  logic [RA_W-1:0]  stored;

  assign self_mask = {{(SLOTS-1){1'b0}}, 1'b1} << slot;
  assign stored    = addr_flat[slot*RA_W +: RA_W];
  assign tgt_open  = open_flags[slot];
  // Slow-page target: every other page goes. Otherwise only slow-page pages go.
  assign kill_mask = sel_edo ? ~self_mask : (edo_slots & ~self_mask);
  assign conflict  = |(open_flags & kill_mask);

  always_comb begin
    if (tgt_open && stored == raddr) kind = KIND_HIT;
    else if (tgt_open || conflict)   kind = KIND_MISS;
    else                             kind = KIND_EMPTY;
  end
endmodule

// File: rtl/dpt_store.sv
module dpt_store #(
  parameter int SLOTS = 32,
  parameter int RA_W = 14,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_all,
  input  logic                  wr_en,
  input  logic [SLOT_W-1:0]     wr_slot,
  input  logic [RA_W-1:0]       wr_addr,
  input  logic [SLOTS-1:0]      kill_mask,
  output logic [SLOTS-1:0]      open_flags,
  output logic [SLOTS*RA_W-1:0] addr_flat
);
  logic [SLOTS-1:0] set_mask;
  assign set_mask = {{(SLOTS-1){1'b0}}, 1'b1} << wr_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_flags <= '0;
      addr_flat  <= '0;
    end else if (clr_all) begin
      open_flags <= '0;
    end else if (wr_en) begin
      open_flags <= (open_flags & ~kill_mask) | set_mask;
      addr_flat[wr_slot*RA_W +: RA_W] <= wr_addr;
    end
  end

  assert_close_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> open_flags == '0);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all && !wr_en) |=> $stable(open_flags));
  assert_open_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> |(open_flags & $past(set_mask)));
endmodule

// File: rtl/dram_page_tracker.sv
module dram_page_tracker
  import dpt_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int RA_W = 14,
  localparam int NUM_ROWS = 1 << ROW_W,
  localparam int SLOTS = NUM_ROWS * BANKS_PER_ROW,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ROWS-1:0] cfg_edo,
  input  logic [NUM_ROWS-1:0] cfg_big,
  input  logic                acc_valid,
  input  logic [ROW_W-1:0]    acc_row,
  input  logic [BANK_W-1:0]   acc_bank,
  input  logic [RA_W-1:0]     acc_raddr,
  input  logic                close_all,
  output logic                result_valid,
  output logic [1:0]          result_kind,
  output logic [SLOTS-1:0]    open_flags
);
  logic                  sel_edo, bad_bank, tgt_open, conflict;
  logic [SLOTS-1:0]      edo_slots, legal_slots, kill_mask;
  logic [SLOTS*RA_W-1:0] addr_flat;
  logic [SLOT_W-1:0]     slot;
  kind_e                 kind, kind_q;
  logic                  acc_go, wr_en, valid_q;

  assign slot   = SLOT_W'(slot_of(int'(acc_row), int'(acc_bank)));
  assign acc_go = acc_valid && !close_all;
  assign wr_en  = acc_go && !bad_bank && kind != KIND_HIT;

  dpt_rowcfg #(.ROW_W(ROW_W)) rowcfg_i (
    .cfg_edo(cfg_edo), .cfg_big(cfg_big), .acc_row(acc_row), .acc_bank(acc_bank),
    .sel_edo(sel_edo), .bad_bank(bad_bank), .edo_slots(edo_slots),
    .legal_slots(legal_slots)
  );

  dpt_lookup #(.SLOTS(SLOTS), .RA_W(RA_W)) lookup_i (
    .open_flags(open_flags), .addr_flat(addr_flat), .slot(slot), .raddr(acc_raddr),
    .sel_edo(sel_edo), .edo_slots(edo_slots), .kind(kind), .kill_mask(kill_mask),
    .tgt_open(tgt_open), .conflict(conflict)
  );

  dpt_store #(.SLOTS(SLOTS), .RA_W(RA_W)) store_i (
    .clk(clk), .rst_n(rst_n), .clr_all(close_all), .wr_en(wr_en), .wr_slot(slot),
    .wr_addr(acc_raddr), .kill_mask(kill_mask), .open_flags(open_flags),
    .addr_flat(addr_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= KIND_HIT;
    end else begin
      valid_q <= acc_go;
      kind_q  <= bad_bank ? KIND_ERROR : kind;
    end
  end

  assign result_valid = valid_q;
  assign result_kind  = kind_q;

  assert_result_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(acc_valid && !close_all));
  assert_error_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && bad_bank) |=> $stable(open_flags) && result_kind == 2'd3);
  assert_edo_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    |(open_flags & edo_slots) |-> $countones(open_flags) == 1);
  assert_within_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_flags & ~legal_slots) == '0);
  assert_hit_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !bad_bank && tgt_open && !conflict && kind == KIND_HIT) |=> $stable(open_flags));
endmodule

// File: tb/dram_page_tracker_tb.sv
`timescale 1ns/1ps
module dram_page_tracker_tb_top;
  localparam int RW = 2;
  localparam int NR = 1 << RW;
  localparam int SL = NR * 4;
  localparam int RA = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] cfg_edo = '0, cfg_big = '0;
  logic acc_valid = 1'b0, close_all = 1'b0;
  logic [RW-1:0] acc_row = '0;
  logic [1:0] acc_bank = '0;
  logic [RA-1:0] acc_raddr = '0;
  logic result_valid;
  logic [1:0] result_kind;
  logic [SL-1:0] open_flags;

  int n_checks = 0, n_fail = 0;
  bit m_open[SL];
  logic [RA-1:0] m_addr[SL];

  always #2 clk = ~clk;

  dram_page_tracker #(.ROW_W(RW), .RA_W(RA)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_edo(cfg_edo), .cfg_big(cfg_big),
    .acc_valid(acc_valid), .acc_row(acc_row), .acc_bank(acc_bank),
    .acc_raddr(acc_raddr), .close_all(close_all), .result_valid(result_valid),
    .result_kind(result_kind), .open_flags(open_flags)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SL-1:0] model_flags();
    logic [SL-1:0] v = '0;
    for (int j = 0; j < SL; j++) v[j] = m_open[j];
    return v;
  endfunction

  task automatic restart(input logic [NR-1:0] e, input logic [NR-1:0] g);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_edo = e;
    cfg_big = g;
    for (int j = 0; j < SL; j++) begin m_open[j] = 0; m_addr[j] = '0; end
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset flags", open_flags, 0);
    check("R10 reset valid", result_valid, 0);
  endtask

  task automatic access(input int r, input int b, input int a);
    int lim, s, kind;
    bit conflict;
    string tag;
    lim = cfg_edo[r] ? 1 : (cfg_big[r] ? 4 : 2);
    s = r * 4 + b;
    conflict = 0;
    if (b >= lim) begin
      kind = 3; tag = "R8";
    end else if (m_open[s] && m_addr[s] == a[RA-1:0]) begin
      kind = 0; tag = "R1";
    end else begin
      for (int j = 0; j < SL; j++)
        if (j != s && m_open[j] && (cfg_edo[r] || cfg_edo[j/4])) begin
          conflict = 1; m_open[j] = 0;
        end
      kind = (m_open[s] || conflict) ? 1 : 2;
      if (conflict) tag = cfg_edo[r] ? "R4" : "R7";
      else tag = (kind == 1) ? "R2" : "R3";
      m_open[s] = 1;
      m_addr[s] = a[RA-1:0];
    end
    @(negedge clk);
    acc_valid = 1'b1;
    acc_row = RW'(r);
    acc_bank = 2'(b);
    acc_raddr = RA'(a);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R10 valid", result_valid, 1);
    check({tag, " kind"}, result_kind, kind);
    check(cfg_edo[r] ? "R4 flags" : (cfg_big[r] ? "R6 flags" : "R5 flags"),
          open_flags, model_flags());
  endtask

  task automatic sweep();
    for (int p = 0; p < 6; p++)
      for (int r = 0; r < NR; r++)
        for (int b = 0; b < 4; b++)
          access(r, b, (p / 2) * 5 + ((p % 2) & (r == 2 ? 1 : 0)));
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // Mixed: row0 slow-page, row1 two banks, row2 four banks, row3 slow-page.
    restart(4'b1001, 4'b1100);
    @(negedge clk);
    check("R10 idle valid", result_valid, 0);
    access(1, 0, 3);
    access(1, 1, 4);
    check("R5 two open", open_flags, 16'h0030);
    access(2, 3, 7);
    access(2, 0, 7);
    check("R6 banks", open_flags, 16'h0930);
    access(0, 0, 2);
    check("R4 alone", open_flags, 16'h0001);
    access(1, 1, 2);
    check("R7 closed", open_flags, 16'h0020);
    access(1, 2, 9);
    access(0, 1, 9);
    sweep();
    // close_all with a competing access
    access(2, 1, 1);
    @(negedge clk);
    close_all = 1'b1;
    acc_valid = 1'b1;
    acc_row = 2'd1;
    acc_bank = 2'd0;
    @(negedge clk);
    close_all = 1'b0;
    acc_valid = 1'b0;
    for (int j = 0; j < SL; j++) m_open[j] = 0;
    check("R9 flags cleared", open_flags, 0);
    check("R9 no result", result_valid, 0);
    access(2, 1, 1);
    check("R11 slot bit", open_flags, 16'h0200);

    restart(4'b0000, 4'b0101);
    sweep();
    restart(4'b1111, 4'b0000);
    sweep();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule